// File: doc/BRIEF.md
# CAN Bit-Level Protocol Error Detector

This block sits next to a CAN node's bit sequencer and checks every sampled bus bit for the five protocol error classes: checksum mismatch, missing acknowledge, fixed-form violation, transmit/readback mismatch and stuffing violation. On each bit-sample strobe it receives several inputs. These are the level the node is driving, the level read back from the bus, whether the node is currently the transmitter, a field code from the external frame sequencer, and a flag that marks the current bit as a stuff bit.

The block keeps its own CRC-15 register and a run-length counter for stuffing. It needs no other frame state. It raises a one-cycle pulse for each error class in the same cycle as the strobe. An OR of all the classes gives an error-frame request, which the sequencer uses to abort the frame and schedule a retransmission. The block does not parse frames, remove stuff bits or drive error frames.

Top module: `can_err_detect`

## Requirements
- R1: Bus level 0 is dominant and 1 is recessive. After reset, and in any cycle where `bit_stb` is low, all six error outputs are low.
- R2: Field codes are: 0 idle, 1 start of frame, 2 arbitration, 3 control, 4 data, 5 CRC, 6 CRC delimiter, 7 ACK slot, 8 ACK delimiter, 9 end of frame, 10 intermission. The CRC-15 uses polynomial 0x4599 and is cleared at start of frame. It covers the sampled bits from start of frame through the data field. `crc_err` pulses on the CRC-delimiter strobe when the 15 received CRC-field bits (MSB first) differ from that value.
- R3: Bits strobed with `stuff_bit` high are left out of the CRC calculation. A correctly stuffed frame with a correct CRC gives no `crc_err`.
- R4: When `is_tx` is high and a recessive level is sampled in the ACK slot, `ack_err` pulses. Receivers never raise it.
- R5: A dominant sample in the CRC delimiter, ACK delimiter, end of frame or intermission raises `form_err`. This applies whatever the node's role.
- R6: When `is_tx` is high, a sampled level that differs from the driven level in fields 1 to 9 raises `bit_err`. This holds in both directions.
- R7: Driving recessive while sampling dominant in the arbitration field or the ACK slot raises no `bit_err`.
- R8: On the raw sampled stream, stuff bits included, `stuff_err` pulses on the sixth consecutive equal bit. It pulses again on every further equal bit. The window runs from start of frame through the CRC field.
- R9: Start of frame restarts the run count. Bits outside the start-of-frame-to-CRC window never raise `stuff_err`.
- R10: `err_frame_req` pulses whenever any error output pulses. When several errors fall in the same bit, all of them are reported together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per sampled bus bit |
| fld_code | input | 4 | Field context code from the frame sequencer |
| is_tx | input | 1 | High while the node is transmitting the frame |
| tx_bit | input | 1 | Level the node is driving |
| rx_bit | input | 1 | Level sampled from the bus |
| stuff_bit | input | 1 | Current bit is a stuff bit |
| crc_err | output | 1 | CRC mismatch pulse |
| ack_err | output | 1 | Acknowledge missing pulse |
| form_err | output | 1 | Fixed-form field violation pulse |
| bit_err | output | 1 | Transmit readback mismatch pulse |
| stuff_err | output | 1 | Stuffing rule violation pulse |
| err_frame_req | output | 1 | Request to send an error frame |

## Verification
The bench builds the block with its defaults: a 15-bit CRC with polynomial 0x4599 and a stuffing limit of six. With these values the bench can send complete standard frames, stuffed the way a real bus stuffs them. This exercises the register residue check against an independent long-division CRC, and stuff bits appear that the CRC must skip. The run limit of six also lets short directed bursts reach the stuffing boundary and the window edges. Arbitration loss, a missing acknowledge, and a single bit that raises both a form error and a bit error are driven through the same frame builder.

// File: rtl/can_errdet_pkg.sv
package can_errdet_pkg;

  typedef enum logic [3:0] {
    FLD_IDLE     = 4'd0,
    FLD_SOF      = 4'd1,
    FLD_ARB      = 4'd2,
    FLD_CTRL     = 4'd3,
    FLD_DATA     = 4'd4,
    FLD_CRC      = 4'd5,
    FLD_CRC_DLM  = 4'd6,
    FLD_ACK_SLOT = 4'd7,
    FLD_ACK_DLM  = 4'd8,
    FLD_EOF      = 4'd9,
    FLD_IFS      = 4'd10
  } frame_fld_e;

  // Fields after SOF whose bits feed the running CRC
  function automatic logic fld_crc_body(input frame_fld_e f);
    return (f == FLD_ARB) || (f == FLD_CTRL) || (f == FLD_DATA) || (f == FLD_CRC);
  endfunction

  // Fields in which the stuffing rule is enforced
  function automatic logic fld_stuff_window(input frame_fld_e f);
    return (f == FLD_SOF) || fld_crc_body(f);
  endfunction

  // Fixed recessive fields
  function automatic logic fld_fixed_form(input frame_fld_e f);
    return (f == FLD_CRC_DLM) || (f == FLD_ACK_DLM) || (f == FLD_EOF) || (f == FLD_IFS);
  endfunction

  // Fields in which a transmitter compares drive and readback
  function automatic logic fld_tx_checked(input frame_fld_e f);
    return (f != FLD_IDLE) && (f != FLD_IFS) && (f <= FLD_EOF);
  endfunction

  // Fields where a dominant readback over a recessive drive is legal
  function automatic logic fld_overwrite_ok(input frame_fld_e f);
    return (f == FLD_ARB) || (f == FLD_ACK_SLOT);
  endfunction

endpackage

// File: rtl/can_crc_chk.sv
module can_crc_chk
  import can_errdet_pkg::*;
#(
  parameter int               CRC_W    = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  frame_fld_e fld,
  input  logic       rx_bit,
  input  logic       stuff_bit,
  output logic       crc_err
);

  // One serial step of the generator: feedback is incoming bit xor MSB
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur, input logic b);
    logic fb;
    fb = b ^ cur[CRC_W-1];
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  logic [CRC_W-1:0] crc_q;
  logic             sof_hit;
  logic             body_hit;
  logic             residue_bad;

  assign sof_hit     = bit_stb && (fld == FLD_SOF);
  assign body_hit    = bit_stb && fld_crc_body(fld) && !stuff_bit;
  // Running the received CRC field through the register leaves zero on a match
  assign residue_bad = (crc_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= '0;
    else if (sof_hit)  crc_q <= crc_step('0, rx_bit);
    else if (body_hit) crc_q <= crc_step(crc_q, rx_bit);
  end

  assign crc_err = bit_stb && (fld == FLD_CRC_DLM) && residue_bad;

  p_crc_clear_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fld == FLD_SOF && !rx_bit) |=> (crc_q == '0));

  p_crc_skip_stuff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && stuff_bit && fld != FLD_SOF) |=> $stable(crc_q));

endmodule

// File: rtl/can_stuff_chk.sv
module can_stuff_chk
  import can_errdet_pkg::*;
#(
  parameter int STUFF_LIMIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  frame_fld_e fld,
  input  logic       rx_bit,
  output logic       stuff_err
);

  localparam int RUN_W = $clog2(STUFF_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(STUFF_LIMIT);
  localparam logic [RUN_W-1:0] RUN_WARN = RUN_W'(STUFF_LIMIT - 1);

  logic [RUN_W-1:0] run_q;
  logic             last_q;
  logic             same_lvl;
  logic             run_start;
  logic             run_track;

  assign same_lvl  = (rx_bit == last_q);
  assign run_start = bit_stb && (fld == FLD_SOF);
  assign run_track = bit_stb && fld_stuff_window(fld) && (fld != FLD_SOF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (run_start) begin
      run_q  <= RUN_W'(1);
      last_q <= rx_bit;
    end else if (run_track) begin
      if (!same_lvl) begin
        run_q  <= RUN_W'(1);
        last_q <= rx_bit;
      end else if (run_q != RUN_MAX) begin
        run_q  <= run_q + RUN_W'(1);
      end
    end
  end

  assign stuff_err = run_track && same_lvl && (run_q >= RUN_WARN);

  p_run_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);

  p_no_stuff_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !fld_stuff_window(fld)) |-> !stuff_err);

  p_sof_restarts_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fld == FLD_SOF) |=> (run_q == RUN_W'(1)));

endmodule

// File: rtl/can_bit_chk.sv
module can_bit_chk
  import can_errdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  frame_fld_e fld,
  input  logic       is_tx,
  input  logic       tx_bit,
  input  logic       rx_bit,
  output logic       ack_err,
  output logic       form_err,
  output logic       bit_err
);

  logic lvl_mismatch;
  logic overwrite_ok;
  logic no_ack_seen;
  logic fixed_violated;

  assign lvl_mismatch   = tx_bit ^ rx_bit;
  assign overwrite_ok   = fld_overwrite_ok(fld) && tx_bit && !rx_bit;
  assign no_ack_seen    = (fld == FLD_ACK_SLOT) && rx_bit;
  assign fixed_violated = fld_fixed_form(fld) && !rx_bit;

  assign ack_err  = bit_stb && is_tx && no_ack_seen;
  assign form_err = bit_stb && fixed_violated;
  assign bit_err  = bit_stb && is_tx && fld_tx_checked(fld) && lvl_mismatch && !overwrite_ok;

  p_ack_tx_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (is_tx && rx_bit));

  p_form_dominant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    form_err |-> !rx_bit);

  p_bit_needs_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> (is_tx && (tx_bit != rx_bit)));

  p_arb_exempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && (fld == FLD_ARB || fld == FLD_ACK_SLOT) && tx_bit && !rx_bit) |-> !bit_err);

endmodule

// File: rtl/can_err_detect.sv
module can_err_detect
  import can_errdet_pkg::*;
#(
  parameter int               CRC_W       = 15,
  parameter logic [CRC_W-1:0] CRC_POLY    = 15'h4599,
  parameter int               STUFF_LIMIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic [3:0] fld_code,
  input  logic       is_tx,
  input  logic       tx_bit,
  input  logic       rx_bit,
  input  logic       stuff_bit,
  output logic       crc_err,
  output logic       ack_err,
  output logic       form_err,
  output logic       bit_err,
  output logic       stuff_err,
  output logic       err_frame_req
);

  localparam int N_ERR = 5;

  frame_fld_e       fld;
  logic [N_ERR-1:0] err_vec;

  assign fld = frame_fld_e'(fld_code);

  can_crc_chk #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fld(fld),
    .rx_bit(rx_bit), .stuff_bit(stuff_bit), .crc_err(crc_err)
  );

  can_stuff_chk #(.STUFF_LIMIT(STUFF_LIMIT)) u_stuff (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fld(fld),
    .rx_bit(rx_bit), .stuff_err(stuff_err)
  );

  can_bit_chk u_bit (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fld(fld), .is_tx(is_tx),
    .tx_bit(tx_bit), .rx_bit(rx_bit),
    .ack_err(ack_err), .form_err(form_err), .bit_err(bit_err)
  );

  assign err_vec       = {stuff_err, bit_err, form_err, ack_err, crc_err};
  assign err_frame_req = |err_vec;

  p_strobe_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> !err_frame_req);

  p_req_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err || ack_err || form_err || bit_err || stuff_err) |-> err_frame_req);

endmodule

// File: tb/can_err_detect_tb_top.sv
module can_err_detect_tb_top;
  import can_errdet_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic [3:0] fld_code = 4'd0;
  logic is_tx = 1'b0, tx_bit = 1'b1, rx_bit = 1'b1, stuff_bit = 1'b0;
  logic crc_err, ack_err, form_err, bit_err, stuff_err, err_frame_req;

  always #5 clk = ~clk;

  can_err_detect dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fld_code(fld_code),
    .is_tx(is_tx), .tx_bit(tx_bit), .rx_bit(rx_bit), .stuff_bit(stuff_bit),
    .crc_err(crc_err), .ack_err(ack_err), .form_err(form_err),
    .bit_err(bit_err), .stuff_err(stuff_err), .err_frame_req(err_frame_req)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int c_crc, c_ack, c_form, c_bit, c_stuff, c_req;

  // reference model state
  bit m_data[$];
  bit m_crcf[$];
  int m_run = 0;
  bit m_last = 1'b1;

  // frame under construction
  int f_fld[$];
  bit f_bit[$];
  bit f_stf[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Long division of message * x^15 by the 16-bit generator 0xC599
  function automatic logic [14:0] crc15(input bit q[$]);
    int unsigned r = 0;
    for (int i = 0; i < q.size() + 15; i++) begin
      r = (r << 1) | ((i < q.size()) ? int'(q[i]) : 0);
      if ((r & 32'h8000) != 0) r = r ^ 32'hC599;
    end
    return r[14:0];
  endfunction

  task automatic clr_cnt();
    c_crc = 0; c_ack = 0; c_form = 0; c_bit = 0; c_stuff = 0; c_req = 0;
  endtask

  task automatic send_bit(int f, bit tx_role, bit tx, bit rx, bit stf);
    bit e_crc, e_ack, e_form, e_bit, e_stuff;
    logic [14:0] rcv;
    @(negedge clk);
    fld_code = 4'(f); is_tx = tx_role; tx_bit = tx; rx_bit = rx; stuff_bit = stf; bit_stb = 1'b1;
    e_crc = 0; e_stuff = 0;
    if (f == 6) begin
      rcv = '0;
      foreach (m_crcf[i]) rcv = {rcv[13:0], m_crcf[i]};
      e_crc = (rcv != crc15(m_data));
    end
    if (f == 1) begin
      m_data.delete(); m_crcf.delete();
      m_data.push_back(rx); m_run = 1; m_last = rx;
    end else if (f >= 2 && f <= 5) begin
      if (!stf) begin
        if (f == 5) m_crcf.push_back(rx); else m_data.push_back(rx);
      end
      if (rx == m_last) m_run++; else begin m_run = 1; m_last = rx; end
      e_stuff = (m_run >= 6);
    end
    e_ack  = tx_role && f == 7 && rx;
    e_form = (f == 6 || f == 8 || f == 9 || f == 10) && !rx;
    e_bit  = tx_role && f >= 1 && f <= 9 && tx != rx && !((f == 2 || f == 7) && tx && !rx);
    #2;
    check("R2 crc_err", int'(crc_err), int'(e_crc));
    check("R4 ack_err", int'(ack_err), int'(e_ack));
    check("R5 form_err", int'(form_err), int'(e_form));
    check("R6/R7 bit_err", int'(bit_err), int'(e_bit));
    check("R8 stuff_err", int'(stuff_err), int'(e_stuff));
    check("R10 err_frame_req", int'(err_frame_req), int'(e_crc | e_ack | e_form | e_bit | e_stuff));
    c_crc += int'(crc_err); c_ack += int'(ack_err); c_form += int'(form_err);
    c_bit += int'(bit_err); c_stuff += int'(stuff_err); c_req += int'(err_frame_req);
    @(negedge clk);
    bit_stb = 1'b0;
    #2;
    check("R1 no strobe", int'(err_frame_req), 0);
  endtask

  task automatic build_frame(int nbytes, logic [7:0] b0, bit nostuff);
    bit lb[$];
    int lf[$];
    logic [14:0] c;
    logic [5:0] ctrl;
    logic [7:0] d;
    int run;
    bit last;
    f_fld.delete(); f_bit.delete(); f_stf.delete();
    lb.push_back(1'b0); lf.push_back(1);
    for (int i = 10; i >= 0; i--) begin lb.push_back(11'h2B7 >> i); lf.push_back(2); end
    ctrl = {2'b00, 4'(nbytes)};
    for (int i = 5; i >= 0; i--) begin lb.push_back(ctrl[i]); lf.push_back(3); end
    for (int k = 0; k < nbytes; k++) begin
      d = (k == 0) ? b0 : (b0 ^ 8'(k * 8'h5B));
      for (int i = 7; i >= 0; i--) begin lb.push_back(d[i]); lf.push_back(4); end
    end
    c = crc15(lb);
    for (int i = 14; i >= 0; i--) begin lb.push_back(c[i]); lf.push_back(5); end
    run = 0; last = 1'b1;
    foreach (lb[i]) begin
      f_fld.push_back(lf[i]); f_bit.push_back(lb[i]); f_stf.push_back(1'b0);
      if (lb[i] == last && i != 0) run++; else begin run = 1; last = lb[i]; end
      if (!nostuff && run == 5) begin
        f_fld.push_back(lf[i]); f_bit.push_back(~last); f_stf.push_back(1'b1);
        last = ~last; run = 1;
      end
    end
    f_fld.push_back(6); f_bit.push_back(1'b1); f_stf.push_back(1'b0);
    f_fld.push_back(7); f_bit.push_back(1'b1); f_stf.push_back(1'b0);
    f_fld.push_back(8); f_bit.push_back(1'b1); f_stf.push_back(1'b0);
    for (int i = 0; i < 7; i++) begin f_fld.push_back(9); f_bit.push_back(1'b1); f_stf.push_back(1'b0); end
    for (int i = 0; i < 3; i++) begin f_fld.push_back(10); f_bit.push_back(1'b1); f_stf.push_back(1'b0); end
  endtask

  task automatic send_frame(bit tx_role, bit acked, int flip);
    bit tx, rx;
    clr_cnt();
    foreach (f_fld[i]) begin
      if (tx_role) begin
        tx = f_bit[i]; rx = tx;
        if (f_fld[i] == 7) rx = !acked;
      end else begin
        tx = 1'b1; rx = f_bit[i];
        if (f_fld[i] == 7) begin tx = !acked; rx = !acked; end
      end
      if (i == flip) rx = ~rx;
      send_bit(f_fld[i], tx_role, tx, rx, f_stf[i]);
    end
  endtask

  function automatic int find_bit(int f, bit v);
    foreach (f_fld[i]) if (f_fld[i] == f && f_bit[i] == v && !f_stf[i]) return i;
    return -1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset crc", int'(crc_err), 0);
    check("R1 reset req", int'(err_frame_req), 0);
    check("R1 reset stuff", int'(stuff_err), 0);
    rst_n = 1'b1;

    // Receiver, good stuffed frame with long runs (R3)
    build_frame(2, 8'h00, 1'b0);
    send_frame(1'b0, 1'b1, -1);
    check("R3 stuffed frame crc pulses", c_crc, 0);
    check("R3 stuffed frame stuff pulses", c_stuff, 0);

    // Transmitter, acknowledged, good frame: ACK overwrite exempt (R7)
    build_frame(3, 8'hFF, 1'b0);
    send_frame(1'b1, 1'b1, -1);
    check("R7 acked tx bit pulses", c_bit, 0);
    check("R10 clean frame req pulses", c_req, 0);

    // Transmitter, no acknowledge (R4)
    send_frame(1'b1, 1'b0, -1);
    check("R4 ack pulses", c_ack, 1);

    // Receiver, corrupted CRC bit (R2)
    build_frame(1, 8'hA5, 1'b0);
    send_frame(1'b0, 1'b1, find_bit(5, 1'b1));
    check("R2 crc field corrupt", c_crc, 1);

    // Receiver, corrupted data bit (R2)
    send_frame(1'b0, 1'b1, find_bit(4, 1'b0));
    check("R2 data corrupt", c_crc, 1);

    // Transmitter losing arbitration: recessive overwritten (R7)
    build_frame(1, 8'h3C, 1'b0);
    send_frame(1'b1, 1'b1, find_bit(2, 1'b1));
    check("R7 arbitration overwrite", c_bit, 0);

    // Transmitter, dominant driven but recessive read in data (R6)
    send_frame(1'b1, 1'b1, find_bit(4, 1'b0));
    check("R6 data mismatch", c_bit, 1);

    // Receiver, dominant in end of frame (R5)
    send_frame(1'b0, 1'b1, find_bit(9, 1'b1));
    check("R5 eof dominant", c_form, 1);

    // Transmitter, dominant in EOF: form and bit in the same bit (R10)
    send_frame(1'b1, 1'b1, find_bit(9, 1'b1) + 2);
    check("R10 multi form", c_form, 1);
    check("R10 multi bit", c_bit, 1);
    check("R10 multi req", c_req, 1);

    // Unstuffed zero data: stuffing violation (R8)
    build_frame(1, 8'h00, 1'b1);
    send_frame(1'b0, 1'b1, -1);
    check("R8 unstuffed run", int'(c_stuff > 0), 1);

    // Idle dominant run followed by a short run after SOF (R9)
    clr_cnt();
    for (int i = 0; i < 8; i++) send_bit(0, 1'b0, 1'b1, 1'b0, 1'b0);
    send_bit(1, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(2, 1'b0, 1'b1, 1'b0, 1'b0);
    send_bit(2, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R9 window restart", c_stuff, 0);

    // Exactly six equal bits: one pulse on the sixth (R8)
    clr_cnt();
    send_bit(1, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(2, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 sixth bit", c_stuff, 1);
    send_bit(2, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 seventh bit", c_stuff, 2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule